// File: doc/BRIEF.md
# Matrix Keypad Scan and Debounce Controller

This block reads a 4x4 matrix keypad and turns each key press into a single event. It drives one row line low at a time while leaving the other rows high. The column lines are pulled up, so they idle high and are active low. They arrive asynchronously and first pass through a chain of synchronizer flops. While no column reads low, the controller steps through the rows in a fixed order.

When a closed switch shows up on the active row, the controller freezes on that row and records the column. It then waits for a programmable bounce interval and checks the same column again. If the key is still closed, the controller raises a one-clock valid strobe with the key's code. It then stays on that row until every column reads high again. A key that stays down therefore reports only once, and no other key can be recognised until it is released. The intended clock is about 93 kHz. At that rate a bounce interval of about one millisecond is roughly 93 cycles.

Top module: `keyMatrixScanner`

## Requirements
- R1: At every clock after reset, exactly one bit of `rowOut` is 0 and the others are 1. Bit n being 0 means row n is driven.
- R2: While no column reads low, each row is driven for SYNC_STAGES+1 clocks (3 by default), in the order row 0, 1, 2, 3, after which row 0 follows again.
- R3: A press is reported only after its column has been seen closed, and then seen closed again DEBOUNCE_CYCLES clocks later. A press released before that interval ends produces no valid strobe.
- R4: On a report, `keyCode` equals 4*row + column, where column c is bit c of `colRaw`.
- R5: If several columns of the driven row read low at the same time, the lowest-numbered one is reported.
- R6: `keyValid` is high for exactly one clock per press, and a key held down produces no further strobe.
- R7: From the report until all columns read high, the controller keeps driving the same row and ignores every other key. After the release, scanning resumes and another key that is still pressed is then reported.
- R8: While reset is high, `rowOut` is 1110, `keyValid` is 0 and `keyCode` is 0. After reset is released, scanning starts from row 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| colRaw | input | 4 | Raw column lines, active low, asynchronous |
| rowOut | output | 4 | Row drives, active low, one row at a time |
| keyCode | output | 4 | Code of the last reported key, 4*row + column |
| keyValid | output | 1 | One-clock strobe marking a new key report |

## Verification
The bench presses keys on every row and column through a keypad model that reacts to the row drives. It checks the code, and it checks that the strobe lasts one clock and does not come back while the key stays down. A tap shorter than the bounce interval must produce nothing. A design that skipped the second check of the column would report it anyway. Two keys held together on one row must report the lower column, which exposes a reversed priority encoder. A second key pressed while the first is held must stay silent until the first is released and must then be reported. A design that left the wait state early would emit a premature or repeated strobe, or would move off the held row.

// File: rtl/kmsPkg.sv
package kmsPkg;
  typedef enum logic [2:0] {
    ST_SCAN,
    ST_SYNC,
    ST_DEBOUNCE,
    ST_PULSE,
    ST_WAIT
  } scanState_t;

  typedef struct packed {
    logic advanceRow;
    logic latchKey;
    logic clearCnt;
    logic inWait;
  } ctlStrobes_t;

  typedef struct packed {
    logic anyLow;
    logic allHigh;
    logic latchedLow;
    logic settleDone;
    logic debDone;
  } dpStatus_t;
endpackage

// File: rtl/kmsDatapath.sv
module kmsDatapath
  import kmsPkg::*;
#(
  parameter int ROWS = 4,
  parameter int COLS = 4,
  parameter int SYNC_STAGES = 2,
  parameter int DEBOUNCE_CYCLES = 93
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic [COLS-1:0]                    colRaw,
  input  ctlStrobes_t                        ctl,
  output logic [ROWS-1:0]                    rowOut,
  output logic [$clog2(ROWS*COLS)-1:0]       keyCode,
  output dpStatus_t                          status
);
  localparam int ROW_W   = $clog2(ROWS);
  localparam int COL_W   = $clog2(COLS);
  localparam int CODE_W  = $clog2(ROWS*COLS);
  localparam int CNT_MAX = (DEBOUNCE_CYCLES > SYNC_STAGES) ? DEBOUNCE_CYCLES : SYNC_STAGES;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  logic [COLS-1:0] syncQ [SYNC_STAGES];
  logic [COLS-1:0] colSync;
  logic [ROW_W-1:0] rowIdxQ;
  logic [COL_W-1:0] colQ;
  logic [COL_W-1:0] firstLow;
  logic [CNT_W-1:0] cntQ;
  logic [CODE_W-1:0] keyCodeQ;

  // Synchronizer chain for the asynchronous column lines
  genvar s;
  generate
    for (s = 0; s < SYNC_STAGES; s++) begin : gSync
      always_ff @(posedge clk) begin
        if (rst) syncQ[s] <= '1;
        else if (s == 0) syncQ[s] <= colRaw;
        else syncQ[s] <= syncQ[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign colSync = syncQ[SYNC_STAGES-1];

  // Lowest-numbered low column wins
  always_comb begin
    firstLow = '0;
    for (int c = COLS-1; c >= 0; c--) begin
      if (!colSync[c]) firstLow = COL_W'(c);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rowIdxQ  <= '0;
      colQ     <= '0;
      cntQ     <= '0;
      keyCodeQ <= '0;
    end else begin
      if (ctl.clearCnt) cntQ <= '0;
      else if (cntQ != CNT_W'(CNT_MAX)) cntQ <= cntQ + 1'b1;
      if (ctl.advanceRow) begin
        if (rowIdxQ == ROW_W'(ROWS-1)) rowIdxQ <= '0;
        else rowIdxQ <= rowIdxQ + 1'b1;
      end
      if (ctl.latchKey) begin
        colQ     <= firstLow;
        keyCodeQ <= CODE_W'(rowIdxQ) * CODE_W'(COLS) + CODE_W'(firstLow);
      end
    end
  end

  assign rowOut  = ~(ROWS'(1) << rowIdxQ);
  assign keyCode = keyCodeQ;

  assign status.anyLow     = ~&colSync;
  assign status.allHigh    = &colSync;
  assign status.latchedLow = ~colSync[colQ];
  assign status.settleDone = (cntQ == CNT_W'(SYNC_STAGES-1));
  assign status.debDone    = (cntQ == CNT_W'(DEBOUNCE_CYCLES-1));

  assert_one_row_R1: assert property (@(posedge clk) disable iff (rst)
    $countones(rowOut) == ROWS-1);

  assert_hold_row_in_wait_R7: assert property (@(posedge clk) disable iff (rst)
    (ctl.inWait && $past(ctl.inWait) && !$past(rst)) |-> $stable(rowIdxQ));
endmodule

// File: rtl/kmsControl.sv
module kmsControl
  import kmsPkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  dpStatus_t   status,
  output ctlStrobes_t ctl,
  output logic        keyValid
);
  scanState_t stateQ, stateD;

  always_comb begin
    stateD = stateQ;
    ctl    = '0;
    unique case (stateQ)
      ST_SCAN: begin
        stateD       = ST_SYNC;
        ctl.clearCnt = 1'b1;
      end
      ST_SYNC: begin
        if (status.settleDone) begin
          ctl.clearCnt = 1'b1;
          if (status.anyLow) begin
            stateD       = ST_DEBOUNCE;
            ctl.latchKey = 1'b1;
          end else begin
            stateD         = ST_SCAN;
            ctl.advanceRow = 1'b1;
          end
        end
      end
      ST_DEBOUNCE: begin
        if (status.debDone) begin
          if (status.latchedLow) begin
            stateD = ST_PULSE;
          end else begin
            stateD         = ST_SCAN;
            ctl.advanceRow = 1'b1;
            ctl.clearCnt   = 1'b1;
          end
        end
      end
      ST_PULSE: stateD = ST_WAIT;
      ST_WAIT: begin
        ctl.inWait = 1'b1;
        if (status.allHigh) begin
          stateD         = ST_SCAN;
          ctl.advanceRow = 1'b1;
          ctl.clearCnt   = 1'b1;
        end
      end
      default: stateD = ST_SCAN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) stateQ <= ST_SCAN;
    else stateQ <= stateD;
  end

  assign keyValid = (stateQ == ST_PULSE);

  assert_valid_one_cycle_R6: assert property (@(posedge clk) disable iff (rst)
    keyValid |=> !keyValid);

  assert_pulse_after_debounce_R3: assert property (@(posedge clk) disable iff (rst)
    (keyValid && !$past(rst)) |-> $past(stateQ) == ST_DEBOUNCE);

  assert_reset_state_R8: assert property (@(posedge clk)
    rst |=> (stateQ == ST_SCAN && !keyValid));
endmodule

// File: rtl/keyMatrixScanner.sv
module keyMatrixScanner
  import kmsPkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DEBOUNCE_CYCLES = 93
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [3:0] colRaw,
  output logic [3:0] rowOut,
  output logic [3:0] keyCode,
  output logic       keyValid
);
  ctlStrobes_t ctl;
  dpStatus_t   status;

  kmsDatapath #(
    .ROWS(4), .COLS(4), .SYNC_STAGES(SYNC_STAGES), .DEBOUNCE_CYCLES(DEBOUNCE_CYCLES)
  ) dp_i (
    .clk(clk), .rst(rst), .colRaw(colRaw), .ctl(ctl),
    .rowOut(rowOut), .keyCode(keyCode), .status(status)
  );

  kmsControl ctrl_i (
    .clk(clk), .rst(rst), .status(status), .ctl(ctl), .keyValid(keyValid)
  );
endmodule

// File: tb/keyMatrixScanner_tb_top.sv
`timescale 1ns/1ps
module keyMatrixScanner_tb_top;
  localparam int DB = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [3:0] colRaw, rowOut, keyCode;
  logic keyValid;
  logic [15:0] pressed = '0;
  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  keyMatrixScanner #(.SYNC_STAGES(2), .DEBOUNCE_CYCLES(DB)) dut_i (
    .clk(clk), .rst(rst), .colRaw(colRaw),
    .rowOut(rowOut), .keyCode(keyCode), .keyValid(keyValid)
  );

  // Keypad model: a closed switch pulls its column low when its row is driven
  always_comb begin
    for (int c = 0; c < 4; c++) begin
      colRaw[c] = 1'b1;
      for (int r = 0; r < 4; r++)
        if (pressed[r*4+c] && !rowOut[r]) colRaw[c] = 1'b0;
    end
  end

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Waits for a strobe; returns cycles waited (limit if none)
  task automatic waitValid(input int limit, output int n);
    n = 0;
    while (n < limit) begin
      @(negedge clk);
      n++;
      if (keyValid) break;
    end
  endtask

  task automatic holdCount(input int cycles, output int pulses, output logic rowSteady,
                           input logic [3:0] rowExp);
    pulses = 0;
    rowSteady = 1'b1;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (keyValid) pulses++;
      if (rowOut !== rowExp) rowSteady = 1'b0;
    end
  endtask

  localparam logic [3:0] VEC [0:7] = '{4'h0, 4'h5, 4'hA, 4'hF, 4'h3, 4'hC, 4'h6, 4'h9};

  initial begin
    int n, pulses;
    logic steady;
    repeat (4) @(negedge clk);
    // R8 reset state
    chk(rowOut == 4'b1110, "R8 rowOut in reset", rowOut, 14);
    chk(keyValid == 1'b0, "R8 keyValid in reset", keyValid, 0);
    chk(keyCode == 4'h0, "R8 keyCode in reset", keyCode, 0);
    rst = 1'b0;
    // R2 scan order and dwell; R1 one row at a time
    for (int k = 0; k < 15; k++) begin
      automatic logic [3:0] expRow = ~(4'b0001 << ((k / 3) % 4));
      if (k > 0) @(negedge clk);
      chk(rowOut == expRow, "R2 scan sequence", rowOut, expRow);
      chk($countones(rowOut) == 3, "R1 single row", $countones(rowOut), 3);
    end
    repeat (7) @(negedge clk);

    // Vector table: single presses
    for (int v = 0; v < 8; v++) begin
      automatic int row = VEC[v] / 4;
      automatic int col = VEC[v] % 4;
      automatic logic [3:0] rowExp = ~(4'b0001 << row);
      pressed = '0;
      pressed[row*4+col] = 1'b1;
      waitValid(300, n);
      chk(keyValid == 1'b1, "R6 strobe seen", keyValid, 1);
      chk(keyCode == 4'(row*4+col), "R4 key code", keyCode, row*4+col);
      chk(n > DB, "R3 report after bounce interval", n, DB + 1);
      @(negedge clk);
      chk(keyValid == 1'b0, "R6 strobe one cycle", keyValid, 0);
      holdCount(40, pulses, steady, rowExp);
      chk(pulses == 0, "R6 no repeat while held", pulses, 0);
      chk(steady, "R7 row held while key down", steady, 1);
      pressed = '0;
      holdCount(30, pulses, steady, rowExp);
      chk(pulses == 0, "R6 no strobe on release", pulses, 0);
    end

    // R3 short tap is discarded
    pressed[1*4+2] = 1'b1;
    repeat (10) @(negedge clk);
    pressed = '0;
    holdCount(60, pulses, steady, 4'b0000);
    chk(pulses == 0, "R3 short tap ignored", pulses, 0);

    // R5 two columns low on one row
    pressed[2*4+3] = 1'b1;
    pressed[2*4+1] = 1'b1;
    waitValid(300, n);
    chk(keyValid && keyCode == 4'd9, "R5 lowest column wins", keyCode, 9);
    pressed = '0;
    repeat (30) @(negedge clk);

    // R7 lockout of a second key while first is held
    pressed[0*4+2] = 1'b1;
    waitValid(300, n);
    chk(keyValid && keyCode == 4'd2, "R7 first key", keyCode, 2);
    pressed[3*4+0] = 1'b1;
    holdCount(60, pulses, steady, 4'b1110);
    chk(pulses == 0, "R7 second key locked out", pulses, 0);
    chk(steady, "R7 row stays on held key", steady, 1);
    pressed[0*4+2] = 1'b0;
    waitValid(300, n);
    chk(keyValid && keyCode == 4'd12, "R7 second key after release", keyCode, 12);
    pressed = '0;
    repeat (30) @(negedge clk);

    // R8 reset mid-run
    rst = 1'b1;
    @(negedge clk);
    chk(rowOut == 4'b1110 && !keyValid && keyCode == 0, "R8 reset again", keyCode, 0);
    rst = 1'b0;

    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule